// File: doc/BRIEF.md
# Masked Compare-Subtract Unit

This block is an ALU slice for a byte-wide processor core. It performs one operation: the accumulator and the index register are ANDed, the immediate operand is subtracted from that mask, and the difference goes back into the index register. The flags are updated the way a compare updates them, and not the way a subtract-with-borrow does. The incoming carry plays no part in the subtraction. The decimal-mode flag has no effect, so the arithmetic is always binary. The overflow flag passes through unchanged.

The core presents the operands, its current flags and a one-cycle strobe. One clock later the block returns the new index value, the unchanged accumulator, the updated flags and a result strobe. Between strobes the outputs keep their last values. Opcode decode and operand fetch belong to the surrounding core.

Top module: `masked_sub_unit`

## Requirements
- R1: One clock after `valid_i` is high, `idx_o` equals (`acc_i` AND `idx_i`) minus `imm_i`, modulo 2^WIDTH.
- R2: `dec_i` has no effect on the result or the carry, which are always binary, and `dec_o` returns `dec_i` unchanged.
- R3: `carry_i` does not act as a borrow, so the result is the same for either value of `carry_i`.
- R4: `carry_o` is 1 exactly when (`acc_i` AND `idx_i`) is greater than or equal to `imm_i`, compared unsigned.
- R5: `ovf_o` returns `ovf_i` unchanged.
- R6: `neg_o` is bit WIDTH-1 (bit 7 by default) of the new result, and `zero_o` is 1 exactly when that result is zero.
- R7: `acc_o` returns `acc_i` unchanged.
- R8: `valid_o` follows `valid_i` by one clock. While `valid_i` is low, all other outputs hold their values.
- R9: While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and flags are valid this cycle |
| acc_i | input | WIDTH | Accumulator |
| idx_i | input | WIDTH | Index register |
| imm_i | input | WIDTH | Immediate operand |
| carry_i | input | 1 | Incoming carry flag |
| dec_i | input | 1 | Incoming decimal-mode flag |
| ovf_i | input | 1 | Incoming overflow flag |
| neg_i | input | 1 | Incoming negative flag (replaced) |
| zero_i | input | 1 | Incoming zero flag (replaced) |
| valid_o | output | 1 | Result is valid |
| acc_o | output | WIDTH | Accumulator, unchanged |
| idx_o | output | WIDTH | New index value |
| carry_o | output | 1 | No-borrow flag of the compare |
| dec_o | output | 1 | Decimal flag, unchanged |
| ovf_o | output | 1 | Overflow flag, unchanged |
| neg_o | output | 1 | Sign of the result |
| zero_o | output | 1 | Result is zero |

## Verification
The hardest cases to reach are the ones where a correct design differs from a plain subtract-with-borrow only by ignoring a flag. Each case needs a particular mask and immediate. One is a mask equal to the immediate while the incoming carry is clear: ignoring the carry gives zero with carry out set, while using it as a borrow would give all ones. Another is a BCD-looking operand with the decimal flag set, where a decimal adjust would change the result. A third is an AND that clears every bit, so the unsigned compare sits exactly at its boundary. The vector table places these patterns next to ordinary wrap and no-wrap cases. Directed steps then drop the strobe to check that the outputs hold.

// File: rtl/csu_pkg.sv
package csu_pkg;
  typedef struct packed {
    logic c;
    logic d;
    logic v;
    logic n;
    logic z;
  } csu_flags_t;
endpackage

// File: rtl/csu_mask.sv
module csu_mask #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] idx_i,
  output logic [WIDTH-1:0] mask_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign mask_o[b] = acc_i[b] & idx_i[b];
  end
endmodule

// File: rtl/csu_sub.sv
module csu_sub #(
  parameter int WIDTH  = 8,
  parameter bit RIPPLE = 1'b1
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] diff_o,
  output logic             no_borrow_o
);
  localparam int EXT = WIDTH + 1;

  if (RIPPLE) begin : g_ripple
    // a + ~b + 1; carry chain seeded with constant 1, never with the flag
    logic [WIDTH:0] cy;
    assign cy[0] = 1'b1;
    for (genvar b = 0; b < WIDTH; b++) begin : g_fa
      logic nb;
      assign nb        = ~b_i[b];
      assign diff_o[b] = a_i[b] ^ nb ^ cy[b];
      assign cy[b+1]   = (a_i[b] & nb) | (cy[b] & (a_i[b] ^ nb));
    end
    assign no_borrow_o = cy[WIDTH];
  end else begin : g_flat
    logic [EXT-1:0] sum;
    assign sum         = {1'b0, a_i} + {1'b0, ~b_i} + EXT'(1);
    assign diff_o      = sum[WIDTH-1:0];
    assign no_borrow_o = sum[WIDTH];
  end

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      a_r1_diff_wraps: assert (WIDTH'(diff_o + b_i) == a_i);
      a_r4_carry_is_ge: assert (no_borrow_o == (a_i >= b_i));
    end
  end
endmodule

// File: rtl/csu_flags.sv
module csu_flags
  import csu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] res_i,
  input  logic             no_borrow_i,
  input  csu_flags_t       flags_i,
  output csu_flags_t       flags_o
);
  always_comb begin
    flags_o   = flags_i;            // d and v pass through
    flags_o.c = no_borrow_i;
    flags_o.n = res_i[WIDTH-1];
    flags_o.z = (res_i == '0);
  end
endmodule

// File: rtl/masked_sub_unit.sv
module masked_sub_unit
  import csu_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit RIPPLE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] idx_i,
  input  logic [WIDTH-1:0] imm_i,
  input  logic             carry_i,
  input  logic             dec_i,
  input  logic             ovf_i,
  input  logic             neg_i,
  input  logic             zero_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] acc_o,
  output logic [WIDTH-1:0] idx_o,
  output logic             carry_o,
  output logic             dec_o,
  output logic             ovf_o,
  output logic             neg_o,
  output logic             zero_o
);
  logic [WIDTH-1:0] mask, diff;
  logic             no_borrow;
  csu_flags_t       flags_in, flags_nx, flags_q;
  logic [WIDTH-1:0] acc_q, idx_q;
  logic             valid_q;

  assign flags_in = '{c: carry_i, d: dec_i, v: ovf_i, n: neg_i, z: zero_i};

  csu_mask #(.WIDTH(WIDTH)) u_mask (
    .acc_i (acc_i),
    .idx_i (idx_i),
    .mask_o(mask)
  );

  csu_sub #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_sub (
    .a_i        (mask),
    .b_i        (imm_i),
    .diff_o     (diff),
    .no_borrow_o(no_borrow)
  );

  csu_flags #(.WIDTH(WIDTH)) u_flags (
    .res_i      (diff),
    .no_borrow_i(no_borrow),
    .flags_i    (flags_in),
    .flags_o    (flags_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      acc_q   <= '0;
      idx_q   <= '0;
      flags_q <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        acc_q   <= acc_i;
        idx_q   <= diff;
        flags_q <= flags_nx;
      end
    end
  end

  assign valid_o = valid_q;
  assign acc_o   = acc_q;
  assign idx_o   = idx_q;
  assign carry_o = flags_q.c;
  assign dec_o   = flags_q.d;
  assign ovf_o   = flags_q.v;
  assign neg_o   = flags_q.n;
  assign zero_o  = flags_q.z;

  a_r8_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r8_idle_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(idx_o) && $stable(acc_o) && $stable(carry_o)));
  a_r5_ovf_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (ovf_o == $past(ovf_i)));
  a_r2_dec_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (dec_o == $past(dec_i)));
  a_r7_acc_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (acc_o == $past(acc_i)));
  a_r6_zero_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (zero_o == (idx_o == '0)));
  a_r1_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (idx_o == WIDTH'($past(acc_i & idx_i) - $past(imm_i))));
endmodule

// File: tb/tb_masked_sub_unit.sv
`timescale 1ns/1ps
module tb_masked_sub_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [7:0] acc_i = '0, idx_i = '0, imm_i = '0;
  logic       carry_i = 1'b0, dec_i = 1'b0, ovf_i = 1'b0, neg_i = 1'b0, zero_i = 1'b0;
  logic       valid_o, carry_o, dec_o, ovf_o, neg_o, zero_o;
  logic [7:0] acc_o, idx_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  masked_sub_unit dut (.*);

  // {acc, idx, imm, cin, din, vin, exp_res, exp_c, exp_n, exp_z}
  localparam int NV = 8;
  localparam logic [37:0] VEC [NV] = '{
    {8'hFF, 8'hFF, 8'h01, 3'b100, 8'hFE, 3'b110},
    {8'h0F, 8'hF3, 8'h03, 3'b001, 8'h00, 3'b101},
    {8'h00, 8'hFF, 8'h01, 3'b111, 8'hFF, 3'b010},
    {8'h55, 8'hAA, 8'h00, 3'b000, 8'h00, 3'b101},
    {8'hF0, 8'h3C, 8'h40, 3'b101, 8'hF0, 3'b010},
    {8'h99, 8'h99, 8'h0A, 3'b110, 8'h8F, 3'b110},
    {8'h80, 8'h80, 8'h80, 3'b000, 8'h00, 3'b101},
    {8'h7F, 8'hFF, 8'h80, 3'b011, 8'hFF, 3'b010}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] a, x, m, input logic c, d, v);
    @(negedge clk_i);
    acc_i = a; idx_i = x; imm_i = m;
    carry_i = c; dec_i = d; ovf_i = v;
    neg_i = ~neg_i; zero_i = ~zero_i;
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #7;
    // R9 reset state
    check("R9 valid", valid_o, 0);
    check("R9 idx", idx_o, 0);
    check("R9 flags", {carry_o, dec_o, ovf_o, neg_o, zero_o}, 0);
    check("R9 acc", acc_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][37:30], VEC[i][29:22], VEC[i][21:14],
            VEC[i][13], VEC[i][12], VEC[i][11]);
      check("R8 valid_o", valid_o, 1);
      check("R1 result", idx_o, VEC[i][10:3]);
      check("R4 carry", carry_o, VEC[i][2]);
      check("R6 neg", neg_o, VEC[i][1]);
      check("R6 zero", zero_o, VEC[i][0]);
      check("R5 ovf", ovf_o, VEC[i][11]);
      check("R2 dec", dec_o, VEC[i][12]);
      check("R7 acc", acc_o, VEC[i][37:30]);
    end

    // R3: same operands with both carry values give the same result
    apply(8'h80, 8'h80, 8'h80, 1'b1, 1'b0, 1'b0);
    check("R3 cin=1 result", idx_o, 8'h00);
    apply(8'h80, 8'h80, 8'h80, 1'b0, 1'b0, 1'b0);
    check("R3 cin=0 result", idx_o, 8'h00);
    check("R3 cin=0 carry", carry_o, 1);

    // R2: decimal flag set, BCD-looking operands still binary
    apply(8'h25, 8'hFF, 8'h09, 1'b1, 1'b1, 1'b1);
    check("R2 binary result", idx_o, 8'h1C);
    check("R2 dec passthrough", dec_o, 1);

    // R4 boundary: equal operands and one above
    apply(8'h42, 8'hFF, 8'h42, 1'b0, 1'b0, 1'b0);
    check("R4 equal carry", carry_o, 1);
    check("R6 equal zero", zero_o, 1);
    apply(8'h42, 8'hFF, 8'h43, 1'b1, 1'b0, 1'b0);
    check("R4 below carry", carry_o, 0);
    check("R1 below result", idx_o, 8'hFF);

    // R8: outputs hold while valid_i stays low and inputs move
    acc_i = 8'h11; idx_i = 8'h22; imm_i = 8'h33; carry_i = 1'b1; ovf_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R8 valid low", valid_o, 0);
    check("R8 idx hold", idx_o, 8'hFF);
    check("R8 acc hold", acc_o, 8'h42);
    check("R8 carry hold", carry_o, 0);
    check("R8 ovf hold", ovf_o, 0);

    // R9: asynchronous reset clears outputs
    #1 rst_ni = 1'b0;
    #0.5;
    check("R9 async idx", idx_o, 0);
    check("R9 async acc", acc_o, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule